// File: doc/BRIEF.md
# Byte Register File with Indirect Pointer

This block is the data register file of a small processor core. It holds a bank of byte-wide general-purpose locations and an 8-bit pointer register, and it decodes one address as a virtual indirect location. That location has no storage of its own. An access to it is redirected to the location whose address the pointer currently holds. Software walks through a table by loading the pointer once, accessing the virtual location, and then incrementing the pointer.

The core reaches the file through one combinational read port and one write port that commits on the clock edge. Direct and indirect accesses use the same ports. If the pointer holds the address of the virtual location itself, an indirect read returns zero and an indirect write changes nothing. The pointer can be reached indirectly. Addresses that are not implemented read as zero and ignore writes.

Top module: `rfp_regfile`

## Requirements
- R1: After reset the pointer register (address 04h) reads 00h and every general-purpose location reads 00h.
- R2: General-purpose RAM occupies addresses 0Ch to 4Fh (68 bytes). A write with wr_en high stores wr_data on the rising edge. While wr_en is low nothing is stored.
- R3: The pointer register sits at direct address 04h and can be written and read back like any 8-bit register.
- R4: A read of address 00h returns the contents of the location whose address is held in the pointer. After the pointer is incremented, that read reaches the following location.
- R5: A write to address 00h stores wr_data into the location whose address is held in the pointer.
- R6: A read of address 00h while the pointer holds 00h returns 00h.
- R7: A write to address 00h while the pointer holds 00h is a no-operation. The pointer and all RAM contents are unchanged.
- R8: With the pointer holding 04h, address 00h reaches the pointer itself. A read returns 04h and a write replaces the pointer.
- R9: Reads of unimplemented addresses (01h to 03h, 05h to 0Bh, 50h to FFh), directly or through the pointer, return 00h, and writes to them change no stored value.
- R10: Reads are combinational on the state held before the next edge. A read in the same cycle as a write to the same location returns the old value, and the read in the following cycle returns the new value. An indirect read in the same cycle as a pointer write resolves through the old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 8 | Read address, direct or 00h for indirect |
| rd_data | output | 8 | Combinational read data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address, direct or 00h for indirect |
| wr_data | input | 8 | Write data |

## Verification
The read port and the write port act in the same cycle. The sharpest case is a write that retargets the pointer while the read port performs an indirect read, together with a write and a read of the same RAM byte. The bench drives both sides in one cycle. It expects the indirect read to follow the old pointer and the same-cycle read to return the old byte. In the next cycle it expects the new pointer target and the new byte.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
   localparam int unsigned RFP_DATA_W = 8;
   localparam int unsigned RFP_ADDR_W = 8;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_PTR  = 2'd1,
      TGT_RAM  = 2'd2
   } rfp_tgt_e;
endpackage

// File: rtl/rfp_addr_resolve.sv
module rfp_addr_resolve
   import rfp_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned IND_ADDR  = 0,
   parameter int unsigned PTR_ADDR  = 4,
   parameter int unsigned RAM_BASE  = 12,
   parameter int unsigned RAM_DEPTH = 68,
   parameter int unsigned IDX_W     = 7
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] ptr,
   output rfp_tgt_e          kind,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] IND_A  = ADDR_W'(IND_ADDR);
   localparam logic [ADDR_W-1:0] PTR_A  = ADDR_W'(PTR_ADDR);
   localparam logic [ADDR_W:0]   BASE_A = (ADDR_W+1)'(RAM_BASE);
   localparam logic [ADDR_W:0]   END_A  = (ADDR_W+1)'(RAM_BASE + RAM_DEPTH);

   logic [ADDR_W-1:0] eff;
   logic [ADDR_W:0]   eff_x;
   logic [ADDR_W:0]   off;

   always_comb begin
      eff   = (addr == IND_A) ? ptr : addr;
      eff_x = {1'b0, eff};
      off   = eff_x - BASE_A;
      kind  = TGT_NONE;
      idx   = '0;
      if (eff == IND_A) begin
         kind = TGT_NONE;
      end else if (eff == PTR_A) begin
         kind = TGT_PTR;
      end else if (eff_x >= BASE_A && eff_x < END_A) begin
         kind = TGT_RAM;
         idx  = IDX_W'(off);
      end
   end
endmodule

// File: rtl/rfp_ptr_reg.sv
module rfp_ptr_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wr_data;
   end

   // R3: a write is visible on the next cycle
   p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (q == $past(wr_data)));
endmodule

// File: rtl/rfp_ram_bank.sv
module rfp_ram_bank #(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned DEPTH          = 68,
   parameter int unsigned IDX_W          = 7,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
         end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_idx] <= wr_data;
      end
   end

   assign rd_data = rd_en ? mem[rd_idx] : '0;

   // R2 / R10: the read following a write of the same byte sees the new data
   p_read_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(wr_en) && rd_idx == $past(wr_idx)) |-> (rd_data == $past(wr_data)));
endmodule

// File: rtl/rfp_regfile.sv
module rfp_regfile
   import rfp_pkg::*;
#(
   parameter int unsigned DATA_W         = RFP_DATA_W,
   parameter int unsigned ADDR_W         = RFP_ADDR_W,
   parameter int unsigned IND_ADDR       = 0,
   parameter int unsigned PTR_ADDR       = 4,
   parameter int unsigned RAM_BASE       = 12,
   parameter int unsigned RAM_DEPTH      = 68,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int unsigned IDX_W = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
   localparam logic [ADDR_W-1:0] IND_A = ADDR_W'(IND_ADDR);
   localparam logic [ADDR_W-1:0] PTR_A = ADDR_W'(PTR_ADDR);

   if (DATA_W != ADDR_W) begin : g_bad_width
      $error("pointer width must equal address width");
   end
   if (IND_ADDR == PTR_ADDR) begin : g_bad_map
      $error("indirect and pointer addresses must differ");
   end
   if (RAM_BASE <= PTR_ADDR || RAM_BASE <= IND_ADDR) begin : g_bad_base
      $error("RAM must sit above the special registers");
   end
   if (RAM_BASE + RAM_DEPTH > (1 << ADDR_W)) begin : g_bad_span
      $error("RAM does not fit in the address space");
   end

   logic [DATA_W-1:0] ptr_q;
   logic [DATA_W-1:0] ram_rd;
   rfp_tgt_e          rd_kind, wr_kind;
   logic [IDX_W-1:0]  rd_idx, wr_idx;

   rfp_addr_resolve #(
      .ADDR_W(ADDR_W), .IND_ADDR(IND_ADDR), .PTR_ADDR(PTR_ADDR),
      .RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH), .IDX_W(IDX_W)
   ) u_rd_res (
      .addr(rd_addr), .ptr(ptr_q), .kind(rd_kind), .idx(rd_idx)
   );

   rfp_addr_resolve #(
      .ADDR_W(ADDR_W), .IND_ADDR(IND_ADDR), .PTR_ADDR(PTR_ADDR),
      .RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH), .IDX_W(IDX_W)
   ) u_wr_res (
      .addr(wr_addr), .ptr(ptr_q), .kind(wr_kind), .idx(wr_idx)
   );

   rfp_ptr_reg #(.DATA_W(DATA_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && wr_kind == TGT_PTR),
      .wr_data(wr_data),
      .q(ptr_q)
   );

   rfp_ram_bank #(
      .DATA_W(DATA_W), .DEPTH(RAM_DEPTH), .IDX_W(IDX_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_ram (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && wr_kind == TGT_RAM),
      .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_en(rd_kind == TGT_RAM),
      .rd_idx(rd_idx), .rd_data(ram_rd)
   );

   always_comb begin
      unique case (rd_kind)
         TGT_PTR: rd_data = ptr_q;
         TGT_RAM: rd_data = ram_rd;
         default: rd_data = '0;
      endcase
   end

   // R3: the pointer changes only when a write resolves to it
   p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_kind == TGT_PTR) |=> $stable(ptr_q));
   // R6: a self-referencing indirect read gives zero
   p_self_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == IND_A && ptr_q == IND_A) |-> (rd_data == '0));
   // R7: a self-referencing indirect write leaves the pointer alone
   p_self_write_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == IND_A && ptr_q == IND_A) |=> $stable(ptr_q));
   // R8: an indirect read through a pointer to itself returns the pointer address
   p_ind_reads_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == IND_A && ptr_q == PTR_A) |-> (rd_data == DATA_W'(PTR_ADDR)));
   // R9: unimplemented targets read as zero
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_kind == TGT_NONE) |-> (rd_data == '0));
endmodule

// File: tb/rfp_regfile_tb.sv
module rfp_regfile_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rd_addr = 8'h00;
   logic [7:0] rd_data;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = 8'h00;
   logic [7:0] wr_data = 8'h00;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   rfp_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   // Drive one cycle: optional write plus a read whose expected value is queued
   task automatic cyc(input logic we, input logic [7:0] wa, input logic [7:0] wd,
                      input logic [7:0] ra, input logic [7:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
      e.exp = exp; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic rd(input logic [7:0] ra, input logic [7:0] exp, input string tag);
      cyc(1'b0, 8'h00, 8'h00, ra, exp, tag);
   endtask

   task automatic wr(input logic [7:0] wa, input logic [7:0] wd, input string tag);
      cyc(1'b1, wa, wd, 8'h01, 8'h00, tag);
   endtask

   // Monitor: compare the combinational read between edges
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (rd_data !== e.exp) begin
               failures++;
               $display("FAIL %s actual=%02h expected=%02h", e.tag, rd_data, e.exp);
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(8'h04, 8'h00, "R1 pointer after reset");
      rd(8'h0C, 8'h00, "R1 first RAM after reset");
      rd(8'h4F, 8'h00, "R1 last RAM after reset");
      // R10: same-cycle write and read of the same byte
      cyc(1'b1, 8'h0C, 8'hA5, 8'h0C, 8'h00, "R10 old value in write cycle");
      rd(8'h0C, 8'hA5, "R2 direct RAM readback");
      wr(8'h4F, 8'h3C, "R2 write top byte");
      rd(8'h4F, 8'h3C, "R2 top byte readback");
      cyc(1'b0, 8'h0C, 8'h12, 8'h0C, 8'hA5, "R2 no store without enable");
      rd(8'h0C, 8'hA5, "R2 enable low kept byte");
      wr(8'h50, 8'h77, "R9 write above RAM");
      rd(8'h50, 8'h00, "R9 read above RAM");
      wr(8'h0B, 8'h11, "R9 write below RAM");
      rd(8'h0B, 8'h00, "R9 read below RAM");
      rd(8'hFF, 8'h00, "R9 read FFh");
      wr(8'h05, 8'h22, "R9 write 05h");
      rd(8'h05, 8'h00, "R9 read 05h");
      // R10: pointer write alongside an indirect read uses the old pointer
      cyc(1'b1, 8'h04, 8'h0C, 8'h00, 8'h00, "R10 indirect read uses old pointer");
      rd(8'h04, 8'h0C, "R3 pointer readback");
      rd(8'h00, 8'hA5, "R4 indirect read");
      cyc(1'b1, 8'h00, 8'h5A, 8'h0C, 8'hA5, "R10 indirect write old value");
      rd(8'h0C, 8'h5A, "R5 indirect write landed");
      wr(8'h04, 8'h0D, "R4 pointer increment");
      rd(8'h00, 8'h00, "R4 next location empty");
      wr(8'h00, 8'hE1, "R5 indirect write next");
      rd(8'h0D, 8'hE1, "R5 indirect write to 0Dh");
      rd(8'h00, 8'hE1, "R4 indirect read 0Dh");
      rd(8'h0C, 8'h5A, "R5 neighbour untouched");
      wr(8'h04, 8'h4F, "R4 pointer to top");
      rd(8'h00, 8'h3C, "R4 indirect top byte");
      wr(8'h04, 8'h50, "R9 pointer above RAM");
      rd(8'h00, 8'h00, "R9 indirect unmapped read");
      wr(8'h00, 8'h99, "R9 indirect unmapped write");
      rd(8'h04, 8'h50, "R9 pointer unchanged");
      rd(8'h4F, 8'h3C, "R9 top byte unchanged");
      wr(8'h04, 8'h04, "R8 pointer to itself");
      rd(8'h00, 8'h04, "R8 indirect read of pointer");
      wr(8'h00, 8'h20, "R8 indirect write of pointer");
      rd(8'h04, 8'h20, "R8 pointer replaced");
      rd(8'h00, 8'h00, "R8 new target empty");
      wr(8'h04, 8'h00, "R6 pointer to zero");
      rd(8'h00, 8'h00, "R6 self indirect read");
      cyc(1'b1, 8'h00, 8'hFF, 8'h00, 8'h00, "R7 self write cycle");
      rd(8'h04, 8'h00, "R7 pointer unchanged");
      rd(8'h0C, 8'h5A, "R7 RAM 0Ch unchanged");
      rd(8'h0D, 8'hE1, "R7 RAM 0Dh unchanged");
      rd(8'h4F, 8'h3C, "R7 RAM 4Fh unchanged");
      rd(8'h00, 8'h00, "R7 self read still zero");
      @(negedge clk);
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd(8'h0C, 8'h00, "R1 RAM cleared by reset");
      rd(8'h0D, 8'h00, "R1 RAM 0Dh cleared by reset");
      rd(8'h04, 8'h00, "R1 pointer cleared by reset");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule